// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block captures a bank of parallel inputs into a chain of stages and streams them out on one serial line. While the active-low load control is held low, every stage follows its parallel input, and no clock activity can disturb it. With the load control high, each rising edge of the combined clock shifts the chain by one place. The new bit enters the first stage from a serial input, and the last stage drives the serial output and its inverse. Several of these registers can be chained by feeding one serial output into the next serial input.

The combined clock is the OR of two interchangeable tick inputs. Holding either one high blocks shifting, so it acts as an inhibit. A rise on one while the other is low counts as a shift edge. All of the control pins and the serial input are asynchronous to the system clock. They pass through a synchronizer, and the combined clock is edge-detected on the free-running system clock, so the design stays fully synchronous.

Top module: `piso_shifter`

## Requirements
- R1: An active-low synchronous reset clears every stage to 0, so after reset `q_ser` reads 0 and `q_ser_n` reads 1.
- R2: While `shld_n` is low, stage i takes `par_in[i]` whatever the tick and serial inputs are doing. Stage 0 is the first stage and stage STAGES-1 is the last.
- R3: With `shld_n` high, a rising edge of (`tick_a` OR `tick_b`) shifts the chain once. Stage 0 takes `ser_in` and stage i takes the old value of stage i-1.
- R4: Each rising edge of the combined tick gives exactly one shift. Holding the combined tick high, or letting it fall, changes nothing.
- R5: While either tick input is held high, toggling the other tick input leaves the stages unchanged.
- R6: The two tick inputs are interchangeable. A rise of either one while the other is low counts as a shift edge, which reproduces the inhibit-rising double-clock hazard.
- R7: `q_ser` carries the last stage and `q_ser_n` carries its inverse.
- R8: If a load and a shift edge arrive in the same system cycle, the load wins and the shift is discarded.
- R9: A combined tick that is already high when reset is released does not cause a shift.
- R10: Every control and serial pin passes through SYNC_DEPTH synchronizer flops. A pin change takes effect on the stages at the (SYNC_DEPTH+1)-th system clock edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shld_n | input | 1 | Low: parallel load; high: shifting allowed |
| tick_a | input | 1 | Clock-style input, ORed with tick_b |
| tick_b | input | 1 | Clock-style input, ORed with tick_a |
| ser_in | input | 1 | Serial bit entering the first stage |
| par_in | input | STAGES | Parallel data, bit i feeds stage i |
| q_ser | output | 1 | Last stage |
| q_ser_n | output | 1 | Inverse of the last stage |

## Verification
A change on any pin reaches the synchronized side after SYNC_DEPTH edges. The stage update follows on the next edge, so with the default depth a load or shift is visible on `q_ser` three system edges after the pin moves. Edges that must cause no change are checked on that same schedule. The bench drives pins at a falling edge, waits four rising edges, and samples at the falling edge that follows, which is always past the due cycle. The reference model is updated at the same moment the bench drives the tick rise, so each comparison sees a settled result.

// File: rtl/piso_pkg.sv
package piso_pkg;
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_LOAD  = 2'd1,
      OP_SHIFT = 2'd2
   } stage_op_e;
endpackage

// File: rtl/pinsync.sv
module pinsync #(
   parameter int              WIDTH     = 4,
   parameter int              DEPTH     = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [DEPTH];

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[s] <= RESET_VAL;
               else        chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[s] <= RESET_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[DEPTH-1];
endmodule

// File: rtl/edge_strobe.sv
module edge_strobe #(
   parameter int SETTLE = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_a,
   input  logic lvl_b,
   output logic strobe
);
   localparam int CW = $clog2(SETTLE + 1) + 1;

   logic          comb_lvl;
   logic          hist;
   logic [CW-1:0] warm;
   logic          primed;

   assign comb_lvl = lvl_a | lvl_b;
   assign primed   = (warm == CW'(SETTLE));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist <= 1'b0;
         warm <= '0;
      end else begin
         hist <= comb_lvl;
         if (!primed) warm <= warm + 1'b1;
      end
   end

   assign strobe = primed & comb_lvl & ~hist;
endmodule

// File: rtl/stage_chain.sv
module stage_chain
   import piso_pkg::*;
#(
   parameter int STAGES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  stage_op_e         op,
   input  logic              ser,
   input  logic [STAGES-1:0] par,
   output logic [STAGES-1:0] stages
);
   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_cell
         logic from_prev;
         if (i == 0) begin : g_head
            assign from_prev = ser;
         end else begin : g_body
            assign from_prev = stages[i-1];
         end
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stages[i] <= 1'b0;
            end else begin
               case (op)
                  OP_LOAD:  stages[i] <= par[i];
                  OP_SHIFT: stages[i] <= from_prev;
                  default:  stages[i] <= stages[i];
               endcase
            end
         end
      end
   endgenerate
endmodule

// File: rtl/piso_shifter.sv
module piso_shifter
   import piso_pkg::*;
#(
   parameter int STAGES     = 8,
   parameter int SYNC_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shld_n,
   input  logic              tick_a,
   input  logic              tick_b,
   input  logic              ser_in,
   input  logic [STAGES-1:0] par_in,
   output logic              q_ser,
   output logic              q_ser_n
);
   localparam int          CTRL_W   = 4;
   localparam logic [CTRL_W-1:0] CTRL_RST = 4'b0001;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("piso_shifter: STAGES must be at least 2");
      end
      if (SYNC_DEPTH < 2) begin : g_bad_sync
         $error("piso_shifter: SYNC_DEPTH must be at least 2");
      end
   endgenerate

   logic [CTRL_W-1:0] raw_ctrl;
   logic [CTRL_W-1:0] syn_ctrl;
   logic              shld_s;
   logic              tick_a_s;
   logic              tick_b_s;
   logic              ser_s;
   logic              shift_stb;
   stage_op_e         op;
   logic [STAGES-1:0] stages;

   assign raw_ctrl = {ser_in, tick_b, tick_a, shld_n};

   pinsync #(
      .WIDTH    (CTRL_W),
      .DEPTH    (SYNC_DEPTH),
      .RESET_VAL(CTRL_RST)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_ctrl),
      .q    (syn_ctrl)
   );

   assign shld_s   = syn_ctrl[0];
   assign tick_a_s = syn_ctrl[1];
   assign tick_b_s = syn_ctrl[2];
   assign ser_s    = syn_ctrl[3];

   edge_strobe #(
      .SETTLE(SYNC_DEPTH + 1)
   ) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_a (tick_a_s),
      .lvl_b (tick_b_s),
      .strobe(shift_stb)
   );

   always_comb begin
      if (!shld_s)        op = OP_LOAD;
      else if (shift_stb) op = OP_SHIFT;
      else                op = OP_HOLD;
   end

   stage_chain #(
      .STAGES(STAGES)
   ) u_chain (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (op),
      .ser   (ser_s),
      .par   (par_in),
      .stages(stages)
   );

   assign q_ser   = stages[STAGES-1];
   assign q_ser_n = ~stages[STAGES-1];
endmodule

// File: rtl/piso_shifter_chk.sv
module piso_shifter_chk #(
   parameter int STAGES = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [STAGES-1:0] par_in,
   input logic              shld_s,
   input logic              shift_stb,
   input logic              ser_s,
   input logic [STAGES-1:0] stages
);
   p_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (stages == '0));

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !shld_s |=> (stages == $past(par_in)));

   p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (shld_s && shift_stb) |=>
         (stages == {$past(stages[STAGES-2:0]), $past(ser_s)}));

   p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      shift_stb |=> !shift_stb);

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (shld_s && !shift_stb) |=> $stable(stages));

   p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!shld_s && shift_stb) |=> (stages == $past(par_in)));

   p_no_edge_after_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !shift_stb);
endmodule

bind piso_shifter piso_shifter_chk #(
   .STAGES(STAGES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .par_in   (par_in),
   .shld_s   (shld_s),
   .shift_stb(shift_stb),
   .ser_s    (ser_s),
   .stages   (stages)
);

// File: tb/tb_piso_shifter.sv
module tb_piso_shifter;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 8;
   localparam int SETTLE     = 4;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         shld_n;
   logic         tick_a;
   logic         tick_b;
   logic         ser_in;
   logic [N-1:0] par_in;
   logic         q_ser;
   logic         q_ser_n;

   logic [N-1:0] model;
   int           checks = 0;
   int           errors = 0;
   bit           done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   piso_shifter #(.STAGES(N), .SYNC_DEPTH(2)) dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .shld_n (shld_n),
      .tick_a (tick_a),
      .tick_b (tick_b),
      .ser_in (ser_in),
      .par_in (par_in),
      .q_ser  (q_ser),
      .q_ser_n(q_ser_n)
   );

   function automatic logic [N-1:0] shifted(logic [N-1:0] v, logic s);
      return {v[N-2:0], s};
   endfunction

   task automatic settle(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_out(string req);
      checks++;
      if (q_ser !== model[N-1] || q_ser_n !== ~model[N-1]) begin
         errors++;
         $display("FAIL %s q_ser=%b q_ser_n=%b expected q_ser=%b q_ser_n=%b",
                  req, q_ser, q_ser_n, model[N-1], ~model[N-1]);
      end
   endtask

   // R2: load with arbitrary tick and serial levels, then release
   task automatic do_load(logic [N-1:0] v, logic ta, logic tb, logic s);
      shld_n = 1'b0; par_in = v; tick_a = ta; tick_b = tb; ser_in = s;
      settle(SETTLE);
      model = v;
      check_out("R2 load");
      shld_n = 1'b1;
      settle(SETTLE);
      check_out("R2 release with ticks held");
      tick_a = 1'b0; tick_b = 1'b0;
      settle(SETTLE);
      check_out("R4 falling tick after load");
   endtask

   // R3/R4/R6: pulse one tick input with the other low
   task automatic pulse(bit use_b, logic s);
      ser_in = s;
      if (use_b) tick_b = 1'b1; else tick_a = 1'b1;
      model = shifted(model, s);
      settle(SETTLE);
      check_out(use_b ? "R6 shift via tick_b" : "R3 shift via tick_a");
      if (use_b) tick_b = 1'b0; else tick_a = 1'b0;
      ser_in = ~s;
      settle(SETTLE);
      check_out("R4 no shift on falling edge");
   endtask

   // R5: hold one input high, toggle the other
   task automatic inhibit_run(bit hold_b, logic s);
      ser_in = s;
      if (hold_b) tick_b = 1'b1; else tick_a = 1'b1;
      model = shifted(model, s);
      settle(SETTLE);
      check_out("R6 inhibit rising acts as edge");
      for (int k = 0; k < 3; k++) begin
         ser_in = ~ser_in;
         if (hold_b) tick_a = 1'b1; else tick_b = 1'b1;
         settle(SETTLE);
         check_out("R5 inhibited rise");
         if (hold_b) tick_a = 1'b0; else tick_b = 1'b0;
         settle(SETTLE);
         check_out("R5 inhibited fall");
      end
      if (hold_b) tick_b = 1'b0; else tick_a = 1'b0;
      settle(SETTLE);
      check_out("R5 inhibit release");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'd20240611);
      rst_n = 1'b0; shld_n = 1'b1; tick_a = 1'b0; tick_b = 1'b0;
      ser_in = 1'b0; par_in = '0; model = '0;
      settle(5);
      check_out("R1 reset state");
      rst_n = 1'b1;
      settle(SETTLE);
      check_out("R1 after reset release");

      // R10: latency, load must be visible on the third edge, not the second
      shld_n = 1'b0; par_in = 8'h80;
      repeat (2) @(posedge clk); @(negedge clk);
      checks++;
      if (q_ser !== 1'b0) begin
         errors++;
         $display("FAIL R10 early q_ser=%b expected 0", q_ser);
      end
      @(posedge clk); @(negedge clk);
      model = 8'h80;
      check_out("R10 load on third edge");
      shld_n = 1'b1;
      settle(SETTLE);

      // R2/R3/R7: load a pattern and drain it bit by bit
      do_load(8'b1010_0110, 1'b1, 1'b0, 1'b1);
      for (int i = 0; i < N; i++) pulse(i[0], 1'b0);
      do_load(8'h5B, 1'b0, 1'b1, 1'b0);
      for (int i = 0; i < N; i++) pulse(1'b0, 1'b1);

      // R5/R6: both inhibit orders
      do_load(8'hC3, 1'b0, 1'b0, 1'b0);
      inhibit_run(1'b1, 1'b1);
      inhibit_run(1'b0, 1'b0);

      // R8: load and edge arrive together, load wins
      do_load(8'h00, 1'b0, 1'b0, 1'b0);
      shld_n = 1'b0; par_in = 8'hFF; tick_a = 1'b1; ser_in = 1'b0;
      model = 8'hFF;
      settle(SETTLE);
      check_out("R8 load wins over edge");
      shld_n = 1'b1;
      settle(SETTLE);
      check_out("R8 no late shift");
      tick_a = 1'b0;
      settle(SETTLE);
      for (int i = 0; i < N; i++) pulse(1'b1, 1'b0);

      // R9: combined tick high across reset release, serial in high
      rst_n = 1'b0; tick_a = 1'b1; ser_in = 1'b1; model = '0;
      settle(5);
      check_out("R1 reset with tick high");
      rst_n = 1'b1;
      settle(8);
      check_out("R9 no shift out of reset");
      tick_a = 1'b0;
      settle(SETTLE);
      for (int i = 0; i < N - 1; i++) pulse(1'b0, 1'b0);

      // random mix
      for (int n = 0; n < 250; n++) begin
         int unsigned r;
         r = $urandom_range(0, 5);
         case (r)
            0: do_load(N'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            1, 2: pulse(1'b0, 1'($urandom));
            3, 4: pulse(1'b1, 1'($urandom));
            default: inhibit_run(1'($urandom), 1'($urandom));
         endcase
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule